// File: doc/BRIEF.md
# Deflection Routing Node Decision Logic

This block is the routing brain of one bufferless two-input, two-output switching node in a multistage deflection-routed fabric. At each slot boundary it looks at the frame flags of its two inputs (north and west) and at the packet header. The two inputs are merged and carry at most one packet per slot. The block then opens exactly one of two output gates, or neither. The south gate passes the packet inward to the next stage. The east gate keeps the packet in the current stage and moves it to a neighbouring node.

A node in an ordinary stage tests a single header bit. The stage index selects which bit: stage 0 tests the most significant bit, stage 1 the next, and so on. The bit is compared against the node's programmed bit. A busy indication from the inner node overrides a match, and the packet is then sent east. Whenever the node sends a packet east, it raises its own busy output toward the outer node that feeds the same target.

A node in the innermost stage compares a multi-bit angle code against the low header bits instead of a single bit. A sticky flag records any slot in which both inputs carried a frame, which the fabric promises never happens.

There is no data stream through this block and no valid/ready handshake. All pins are plain control and status levels, and nothing is ever back-pressured.

Top module: `defl_node_ctrl`

## Requirements
- R1: After reset, gate_south, gate_east, defl_out and collision_err are all 0.
- R2: In a slot with a frame on north or west, normal mode, header bit hdr[HDR_W-1-cfg_cyl_idx] equal to cfg_node_bit and defl_in low, only gate_south is 1 for that slot.
- R3: In a slot with a frame whose selected header bit differs from cfg_node_bit, only gate_east is 1 for that slot.
- R4: In a slot with a frame whose selected bit matches but defl_in is 1, only gate_east is 1 for that slot.
- R5: defl_out is 1 exactly in the slots where gate_east is 1.
- R6: gate_south and gate_east are never 1 together.
- R7: The decision is taken on the clock edge where slot_start is 1 and is held until the next such edge. Input changes while slot_start is 0 have no effect on the outputs.
- R8: In a slot where neither north_frame nor west_frame is 1, both gates and defl_out are 0.
- R9: cfg_cyl_idx selects the tested bit, with index 0 testing the most significant header bit hdr[HDR_W-1].
- R10: With cfg_inner_mode at 1, the match is hdr[ANG_W-1:0] == cfg_angle_code, and cfg_node_bit has no effect.
- R11: collision_err goes to 1 after a slot edge where north_frame and west_frame are both 1, and stays at 1 until reset. Routing in that slot still follows the merged header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| slot_start | input | 1 | marks the edge where a new slot's decision is taken |
| north_frame | input | 1 | frame present on north input |
| west_frame | input | 1 | frame present on west input |
| hdr | input | HDR_W | merged packet header, MSB tested by stage 0 |
| defl_in | input | 1 | busy indication from the inner-stage node |
| cfg_node_bit | input | 1 | programmed bit of this node |
| cfg_cyl_idx | input | IDX_W | stage index selecting the header bit |
| cfg_inner_mode | input | 1 | 1 selects the innermost-stage angle compare |
| cfg_angle_code | input | ANG_W | angle code of the node in innermost mode |
| gate_south | output | 1 | inward gate enable |
| gate_east | output | 1 | deflect gate enable |
| defl_out | output | 1 | busy indication to the outer-stage node |
| collision_err | output | 1 | sticky dual-frame error |

## Verification
Every result is due on the first clock edge at which slot_start is sampled high, and is visible one cycle after the inputs are applied. The outputs then stay unchanged until the next slot edge. The bench applies inputs just after an edge and updates its reference model for the coming edge. It compares all four outputs on every clock, 1 ns after the rising edge, so hold cycles are checked as strictly as decision cycles. The collision flag is checked across later clean slots to confirm that it stays set.

// File: rtl/defl_node_pkg.sv
package defl_node_pkg;
  typedef enum logic [1:0] {
    RT_IDLE  = 2'd0,
    RT_SOUTH = 2'd1,
    RT_EAST  = 2'd2
  } route_e;
endpackage

// File: rtl/defl_hdr_match.sv
module defl_hdr_match #(
  parameter int HDR_W = 4,
  parameter int ANG_W = 2,
  parameter int IDX_W = 2
) (
  input  logic [HDR_W-1:0] hdr,
  input  logic [IDX_W-1:0] cyl_idx,
  input  logic             node_bit,
  input  logic             inner_mode,
  input  logic [ANG_W-1:0] angle_code,
  output logic             match
);
  logic [HDR_W-1:0] sel_onehot;
  logic             picked_bit;
  logic             angle_hit;

  // one-hot selection: stage k tests bit HDR_W-1-k
  for (genvar k = 0; k < HDR_W; k++) begin : g_sel
    assign sel_onehot[HDR_W-1-k] = (cyl_idx == IDX_W'(k));
  end

  assign picked_bit = |(sel_onehot & hdr);

  if (ANG_W <= HDR_W) begin : g_ang
    assign angle_hit = (hdr[ANG_W-1:0] == angle_code);
  end else begin : g_ang_wide
    assign angle_hit = ({{(ANG_W-HDR_W){1'b0}}, hdr} == angle_code);
  end

  assign match = inner_mode ? angle_hit : (picked_bit == node_bit);
endmodule

// File: rtl/defl_route_decide.sv
module defl_route_decide
  import defl_node_pkg::*;
(
  input  logic   north_frame,
  input  logic   west_frame,
  input  logic   match,
  input  logic   defl_in,
  output route_e route_nxt,
  output logic   collide
);
  logic present;

  assign present = north_frame | west_frame;
  assign collide = north_frame & west_frame;

  always_comb begin
    if (!present)                route_nxt = RT_IDLE;
    else if (match && !defl_in)  route_nxt = RT_SOUTH;
    else                         route_nxt = RT_EAST;
  end
endmodule

// File: rtl/defl_slot_reg.sv
module defl_slot_reg
  import defl_node_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   slot_start,
  input  route_e route_nxt,
  input  logic   collide,
  output route_e route_q,
  output logic   busy_q,
  output logic   coll_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= RT_IDLE;
      busy_q  <= 1'b0;
      coll_q  <= 1'b0;
    end else if (slot_start) begin
      route_q <= route_nxt;
      busy_q  <= (route_nxt == RT_EAST);
      coll_q  <= coll_q | collide;
    end
  end
endmodule

// File: rtl/defl_node_ctrl.sv
module defl_node_ctrl
  import defl_node_pkg::*;
#(
  parameter int HDR_W = 4,
  parameter int ANG_W = 2,
  localparam int IDX_W = (HDR_W > 1) ? $clog2(HDR_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic             north_frame,
  input  logic             west_frame,
  input  logic [HDR_W-1:0] hdr,
  input  logic             defl_in,
  input  logic             cfg_node_bit,
  input  logic [IDX_W-1:0] cfg_cyl_idx,
  input  logic             cfg_inner_mode,
  input  logic [ANG_W-1:0] cfg_angle_code,
  output logic             gate_south,
  output logic             gate_east,
  output logic             defl_out,
  output logic             collision_err
);
  logic   match;
  logic   collide;
  route_e route_nxt;
  route_e route_q;

  defl_hdr_match #(.HDR_W(HDR_W), .ANG_W(ANG_W), .IDX_W(IDX_W)) u_match (
    .hdr        (hdr),
    .cyl_idx    (cfg_cyl_idx),
    .node_bit   (cfg_node_bit),
    .inner_mode (cfg_inner_mode),
    .angle_code (cfg_angle_code),
    .match      (match)
  );

  defl_route_decide u_decide (
    .north_frame (north_frame),
    .west_frame  (west_frame),
    .match       (match),
    .defl_in     (defl_in),
    .route_nxt   (route_nxt),
    .collide     (collide)
  );

  defl_slot_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start),
    .route_nxt  (route_nxt),
    .collide    (collide),
    .route_q    (route_q),
    .busy_q     (defl_out),
    .coll_q     (collision_err)
  );

  assign gate_south = (route_q == RT_SOUTH);
  assign gate_east  = (route_q == RT_EAST);
endmodule

// File: rtl/defl_node_ctrl_chk.sv
module defl_node_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic slot_start,
  input logic north_frame,
  input logic west_frame,
  input logic defl_in,
  input logic gate_south,
  input logic gate_east,
  input logic defl_out,
  input logic collision_err
);
  p_gates_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_south && gate_east));

  p_busy_matches_east_r5: assert property (@(posedge clk) disable iff (!rst_n)
    defl_out == gate_east);

  p_hold_between_slots_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot_start) |-> $stable({gate_south, gate_east, defl_out}));

  p_no_frame_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slot_start) && !$past(north_frame) && !$past(west_frame))
      |-> (!gate_south && !gate_east));

  p_busy_in_blocks_south_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slot_start) && $past(defl_in) && ($past(north_frame) || $past(west_frame)))
      |-> (gate_east && !gate_south));

  p_collision_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(collision_err) |-> collision_err);
endmodule

bind defl_node_ctrl defl_node_ctrl_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .slot_start    (slot_start),
  .north_frame   (north_frame),
  .west_frame    (west_frame),
  .defl_in       (defl_in),
  .gate_south    (gate_south),
  .gate_east     (gate_east),
  .defl_out      (defl_out),
  .collision_err (collision_err)
);

// File: tb/defl_node_ctrl_tb_top.sv
`timescale 1ns/1ps
module defl_node_ctrl_tb_top;
  localparam int HDR_W = 4;
  localparam int ANG_W = 2;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_start = 1'b0;
  logic north_frame = 1'b0;
  logic west_frame = 1'b0;
  logic [HDR_W-1:0] hdr = '0;
  logic defl_in = 1'b0;
  logic cfg_node_bit = 1'b0;
  logic [IDX_W-1:0] cfg_cyl_idx = '0;
  logic cfg_inner_mode = 1'b0;
  logic [ANG_W-1:0] cfg_angle_code = '0;
  logic gate_south, gate_east, defl_out, collision_err;

  int checks = 0;
  int failures = 0;

  // reference model state
  bit m_south = 0, m_east = 0, m_coll = 0;

  always #5 clk = ~clk;

  defl_node_ctrl #(.HDR_W(HDR_W), .ANG_W(ANG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .north_frame(north_frame), .west_frame(west_frame), .hdr(hdr),
    .defl_in(defl_in), .cfg_node_bit(cfg_node_bit), .cfg_cyl_idx(cfg_cyl_idx),
    .cfg_inner_mode(cfg_inner_mode), .cfg_angle_code(cfg_angle_code),
    .gate_south(gate_south), .gate_east(gate_east), .defl_out(defl_out),
    .collision_err(collision_err)
  );

  task automatic check(input string tag, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, gate_south, m_south, "gate_south");
    check(tag, gate_east, m_east, "gate_east");
    check("R5", defl_out, m_east, "defl_out");
    check(tag, collision_err, m_coll, "collision_err");
    check("R6", gate_south & gate_east, 1'b0, "both gates");
  endtask

  // apply inputs, advance one clock, update model, compare
  task automatic step(input string tag, input bit ss, input bit n, input bit w,
                      input logic [HDR_W-1:0] h, input bit d);
    bit sel, hit;
    int bitpos;
    slot_start = ss; north_frame = n; west_frame = w; hdr = h; defl_in = d;
    if (ss) begin
      bitpos = HDR_W - 1 - int'(cfg_cyl_idx);
      sel = hdr[bitpos];
      if (cfg_inner_mode) hit = (int'(h % (1 << ANG_W)) == int'(cfg_angle_code));
      else hit = (sel == cfg_node_bit);
      if (!(n || w)) begin m_south = 0; m_east = 0; end
      else if (hit && !d) begin m_south = 1; m_east = 0; end
      else begin m_south = 0; m_east = 1; end
      if (n && w) m_coll = 1;
    end
    @(posedge clk); #1;
    compare_all(tag);
  endtask

  initial begin : watchdog
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", gate_south, 0, "gate_south");
    check("R1", gate_east, 0, "gate_east");
    check("R1", defl_out, 0, "defl_out");
    check("R1", collision_err, 0, "collision_err");
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R8 no frame
    step("R8", 1, 0, 0, 4'hF, 0);
    // R2 match on north, stage 0 tests MSB, node bit 1
    cfg_node_bit = 1; cfg_cyl_idx = 0;
    step("R2", 1, 1, 0, 4'b1000, 0);
    step("R2", 1, 0, 1, 4'b1111, 0);
    // R3 mismatch
    step("R3", 1, 1, 0, 4'b0111, 0);
    // R4 busy input overrides a match
    step("R4", 1, 0, 1, 4'b1000, 1);
    // R8 frame absent even with busy input
    step("R8", 1, 0, 0, 4'b1000, 1);

    // R7 hold: change inputs without slot_start
    step("R2", 1, 1, 0, 4'b1000, 0);
    step("R7", 0, 1, 0, 4'b0000, 1);
    step("R7", 0, 0, 0, 4'b0000, 0);
    step("R7", 0, 1, 1, 4'b0101, 0);
    step("R7", 1, 0, 1, 4'b0000, 0);

    // R9 sweep stage index and node bit
    for (int c = 0; c < HDR_W; c++) begin
      for (int b = 0; b < 2; b++) begin
        cfg_cyl_idx = IDX_W'(c); cfg_node_bit = b[0];
        step("R9", 1, 1, 0, 4'(1 << (HDR_W - 1 - c)), 0);
        step("R9", 1, 0, 1, 4'(~(1 << (HDR_W - 1 - c))), 0);
      end
    end

    // R10 innermost angle compare; node bit must not matter
    cfg_inner_mode = 1;
    for (int a = 0; a < (1 << ANG_W); a++) begin
      cfg_angle_code = ANG_W'(a);
      for (int nb = 0; nb < 2; nb++) begin
        cfg_node_bit = nb[0];
        step("R10", 1, 1, 0, 4'(a | 4'b1100), 0);
        step("R10", 1, 0, 1, 4'((a ^ 1) | 4'b0100), 0);
        step("R10", 1, 1, 0, 4'(a), 1);
      end
    end
    cfg_inner_mode = 0; cfg_cyl_idx = 1; cfg_node_bit = 0;

    // R11 collision: sticky, routing follows merged header
    step("R11", 1, 1, 1, 4'b0000, 0);
    step("R11", 1, 1, 0, 4'b0100, 0);
    step("R11", 1, 0, 0, 4'b0000, 0);
    step("R11", 0, 0, 0, 4'b0000, 0);

    // reset clears the flag
    rst_n = 0; m_south = 0; m_east = 0; m_coll = 0;
    @(posedge clk); #1;
    compare_all("R1");
    rst_n = 1;
    step("R8", 1, 0, 0, 4'b0000, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule